// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block moves data between the volatile working array of a battery-free nonvolatile SRAM and the array's nonvolatile shadow copy. It runs two kinds of transfer. A store first erases the shadow and then programs it from the working array. A recall first clears the working array and then loads it from the shadow. The shadow is never changed by a recall. The array datapath itself is outside the block: the block drives one strobe per phase, and each strobe stays high for the whole of that phase. While a transfer runs, the external bus is gated off and the busy output is high.

Transfers start in three ways. Software can request a store or a recall with a one-cycle pulse. Two supply-monitor flags drive automatic behaviour. One flag means the supply is below the switch level and the other means it is below the reset level. When the supply drops below the switch level, the block runs an automatic store only if the working array was written since the last transfer. Before that store starts, it waits a short grace window so that an array access already in flight can finish. If the supply also goes below the reset level, a recall request is latched. That recall runs when the supply comes back above the switch level. A brown-out that never reaches the reset level returns to normal operation without a recall.

All durations are parameters counted in clock cycles. Reset stands for the first power-up, so it leaves a restore pending.

Top module: `nvx_seq`

## Requirements
- R1: After reset, the block holds the bus off. At the first clock edge that sees the supply above the switch level, it starts a restore: CLEAR_CYC cycles of clear, then RESTLOAD_CYC cycles of load. It then becomes idle with the bus enabled and the modified flag at 0.
- R2: A software store pulse in the idle state, with the supply good, enters erase at the next edge. Erase lasts ERASE_CYC cycles and is followed by PROG_CYC cycles of program. This happens whether or not the modified flag is set.
- R3: A software recall pulse in the idle state, with the supply good, runs CLEAR_CYC cycles of clear and then SWLOAD_CYC cycles of load.
- R4: While any phase strobe is high, busy is 1 and bus_en is 0. The standby output is 1 only when chip_sel is 0 and busy is 0.
- R5: A write strobe sets the modified flag only when the block is idle and the supply is good. Writes during a transfer or during a low-supply wait leave the flag unchanged.
- R6: The modified flag reads 0 after any store or recall completes.
- R7: If the supply goes below the switch level while idle and the flag is set, the block waits AUTO_DELAY_CYC cycles with the bus still enabled. It then runs a full store and afterwards waits with the bus off until the supply recovers.
- R8: If the supply goes below the switch level while the flag is clear, no phase runs. Software store and recall pulses are ignored while the supply is low.
- R9: Any cycle with the reset-level flag high latches a recall. When the supply is next above the switch level during the low-supply wait, a restore of CLEAR_CYC plus RESTLOAD_CYC cycles runs.
- R10: A brown-out recovery with no reset-level event returns to idle with the bus enabled and runs no phase.
- R11: If the supply goes low in the same cycle as a software store pulse, and the flag is set, the automatic path wins. The grace window runs first, so erase is not entered at the next edge.
- R12: At most one phase strobe is high at a time. Program follows only erase, and load follows only clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| sw_store_req | input | 1 | Software store request pulse |
| sw_recall_req | input | 1 | Software recall request pulse |
| sup_low | input | 1 | Supply below switch level |
| sup_dead | input | 1 | Supply below reset level |
| wr_stb | input | 1 | External write strobe |
| chip_sel | input | 1 | Chip selected |
| ph_erase | output | 1 | Shadow erase phase strobe |
| ph_program | output | 1 | Shadow program phase strobe |
| ph_clear | output | 1 | Working-array clear phase strobe |
| ph_load | output | 1 | Working-array load-from-shadow phase strobe |
| busy | output | 1 | A transfer phase is active |
| bus_en | output | 1 | External reads and writes permitted |
| standby | output | 1 | Deselected and no transfer running |
| dirty | output | 1 | Working array modified since last transfer |

## Verification
The bound checker checks properties that must hold on every cycle. It checks that the phase strobes are mutually exclusive and appear in order. It checks that busy gates the bus off and blocks standby. It checks that the modified flag is 0 at the end of every program or load phase, and that writes never set the flag during a transfer. Phase lengths, the grace-window length, and the decisions that depend on history can only be shown by the bench's scenarios. Those decisions are: store only when modified, recall only after a reset-level event, rejection of software requests in low supply, and priority of the automatic store. The bench's scoreboard predicts every phase with its length and reports any phase that appears without being predicted.

// File: rtl/nvx_pkg.sv
package nvx_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_GRACE = 3'd1,
        S_ERASE = 3'd2,
        S_PROG  = 3'd3,
        S_CLEAR = 3'd4,
        S_LOAD  = 3'd5,
        S_DOWN  = 3'd6
    } nvx_state_e;

    typedef struct packed {
        nvx_state_e st;
        logic       auto_run;
        logic       restore_run;
    } nvx_ctl_s;

    function automatic int nvx_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nvx_tick.sv
module nvx_tick #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nvx_flags.sv
module nvx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ok,
    input  logic xfer_end,
    input  logic deep_low,
    input  logic restore_go,
    output logic dirty,
    output logic rec_pend
);
    typedef struct packed {
        logic dirty;
        logic pend;
    } flags_s;

    flags_s fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (xfer_end)      fl_d.dirty = 1'b0;
        else if (wr_ok)    fl_d.dirty = 1'b1;
        if (deep_low)      fl_d.pend  = 1'b1;
        else if (restore_go) fl_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '{dirty: 1'b0, pend: 1'b1};
        else        fl_q <= fl_d;
    end

    assign dirty    = fl_q.dirty;
    assign rec_pend = fl_q.pend;
endmodule

// File: rtl/nvx_seq.sv
module nvx_seq
    import nvx_pkg::*;
#(
    parameter int AUTO_DELAY_CYC = 4,
    parameter int ERASE_CYC      = 6,
    parameter int PROG_CYC       = 8,
    parameter int CLEAR_CYC      = 3,
    parameter int SWLOAD_CYC     = 5,
    parameter int RESTLOAD_CYC   = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_store_req,
    input  logic sw_recall_req,
    input  logic sup_low,
    input  logic sup_dead,
    input  logic wr_stb,
    input  logic chip_sel,
    output logic ph_erase,
    output logic ph_program,
    output logic ph_clear,
    output logic ph_load,
    output logic busy,
    output logic bus_en,
    output logic standby,
    output logic dirty
);
    localparam int MAXC = nvx_max(nvx_max(nvx_max(AUTO_DELAY_CYC, ERASE_CYC),
                                          nvx_max(PROG_CYC, CLEAR_CYC)),
                                  nvx_max(SWLOAD_CYC, RESTLOAD_CYC));
    localparam int CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] L_GRACE = CW'(AUTO_DELAY_CYC - 1);
    localparam logic [CW-1:0] L_ERASE = CW'(ERASE_CYC - 1);
    localparam logic [CW-1:0] L_PROG  = CW'(PROG_CYC - 1);
    localparam logic [CW-1:0] L_CLEAR = CW'(CLEAR_CYC - 1);
    localparam logic [CW-1:0] L_SWLD  = CW'(SWLOAD_CYC - 1);
    localparam logic [CW-1:0] L_RSLD  = CW'(RESTLOAD_CYC - 1);

    nvx_ctl_s      ctl_d, ctl_q;
    logic          ld;
    logic [CW-1:0] ld_val;
    logic          expired;
    logic          xfer_end;
    logic          restore_go;
    logic          wr_ok;
    logic          rec_pend;

    nvx_tick #(.CW(CW)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .expired  (expired)
    );

    nvx_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ok      (wr_ok),
        .xfer_end   (xfer_end),
        .deep_low   (sup_dead),
        .restore_go (restore_go),
        .dirty      (dirty),
        .rec_pend   (rec_pend)
    );

    assign wr_ok = wr_stb && (ctl_q.st == S_IDLE) && !sup_low;

    always_comb begin
        ctl_d      = ctl_q;
        ld         = 1'b0;
        ld_val     = '0;
        xfer_end   = 1'b0;
        restore_go = 1'b0;
        unique case (ctl_q.st)
            S_IDLE: begin
                if (sup_low) begin
                    if (dirty) begin
                        ctl_d.st       = S_GRACE;
                        ctl_d.auto_run = 1'b1;
                        ld             = 1'b1;
                        ld_val         = L_GRACE;
                    end else begin
                        ctl_d.st = S_DOWN;
                    end
                end else if (sw_store_req) begin
                    ctl_d.st       = S_ERASE;
                    ctl_d.auto_run = 1'b0;
                    ld             = 1'b1;
                    ld_val         = L_ERASE;
                end else if (sw_recall_req) begin
                    ctl_d.st          = S_CLEAR;
                    ctl_d.restore_run = 1'b0;
                    ld                = 1'b1;
                    ld_val            = L_CLEAR;
                end
            end
            S_GRACE: begin
                if (expired) begin
                    ctl_d.st = S_ERASE;
                    ld       = 1'b1;
                    ld_val   = L_ERASE;
                end
            end
            S_ERASE: begin
                if (expired) begin
                    ctl_d.st = S_PROG;
                    ld       = 1'b1;
                    ld_val   = L_PROG;
                end
            end
            S_PROG: begin
                if (expired) begin
                    xfer_end       = 1'b1;
                    ctl_d.st       = ctl_q.auto_run ? S_DOWN : S_IDLE;
                    ctl_d.auto_run = 1'b0;
                end
            end
            S_CLEAR: begin
                if (expired) begin
                    ctl_d.st = S_LOAD;
                    ld       = 1'b1;
                    ld_val   = ctl_q.restore_run ? L_RSLD : L_SWLD;
                end
            end
            S_LOAD: begin
                if (expired) begin
                    xfer_end          = 1'b1;
                    ctl_d.st          = S_IDLE;
                    ctl_d.restore_run = 1'b0;
                end
            end
            S_DOWN: begin
                if (!sup_low) begin
                    if (rec_pend) begin
                        ctl_d.st          = S_CLEAR;
                        ctl_d.restore_run = 1'b1;
                        restore_go        = 1'b1;
                        ld                = 1'b1;
                        ld_val            = L_CLEAR;
                    end else begin
                        ctl_d.st = S_IDLE;
                    end
                end
            end
            default: ctl_d.st = S_DOWN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: S_DOWN, auto_run: 1'b0, restore_run: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign ph_erase   = (ctl_q.st == S_ERASE);
    assign ph_program = (ctl_q.st == S_PROG);
    assign ph_clear   = (ctl_q.st == S_CLEAR);
    assign ph_load    = (ctl_q.st == S_LOAD);
    assign busy       = ph_erase | ph_program | ph_clear | ph_load;
    assign bus_en     = (ctl_q.st == S_IDLE) || (ctl_q.st == S_GRACE);
    assign standby    = !chip_sel && !busy;
endmodule

// File: rtl/nvx_seq_chk.sv
module nvx_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_stb,
    input logic chip_sel,
    input logic ph_erase,
    input logic ph_program,
    input logic ph_clear,
    input logic ph_load,
    input logic busy,
    input logic bus_en,
    input logic standby,
    input logic dirty
);
    a_r12_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ph_erase, ph_program, ph_clear, ph_load}));

    a_r12_erase_to_program: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ph_erase) |-> ph_program);

    a_r12_program_after_erase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_program) |-> $past(ph_erase));

    a_r12_clear_to_load: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ph_clear) |-> ph_load);

    a_r12_load_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_load) |-> $past(ph_clear));

    a_r4_bus_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_erase || ph_program || ph_clear || ph_load) |-> (busy && !bus_en));

    a_r4_no_standby_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !standby);

    a_r4_standby_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_sel && !busy) |-> standby);

    a_r6_clean_after_store: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ph_program) |-> !dirty);

    a_r6_clean_after_recall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ph_load) |-> !dirty);

    a_r5_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dirty && wr_stb) |=> !dirty);
endmodule

bind nvx_seq nvx_seq_chk u_nvx_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .chip_sel   (chip_sel),
    .ph_erase   (ph_erase),
    .ph_program (ph_program),
    .ph_clear   (ph_clear),
    .ph_load    (ph_load),
    .busy       (busy),
    .bus_en     (bus_en),
    .standby    (standby),
    .dirty      (dirty)
);

// File: tb/nvx_seq_bench.sv
module nvx_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AUTO_DELAY_CYC = 4;
    localparam int ERASE_CYC      = 6;
    localparam int PROG_CYC       = 8;
    localparam int CLEAR_CYC      = 3;
    localparam int SWLOAD_CYC     = 5;
    localparam int RESTLOAD_CYC   = 12;
    localparam int WATCHDOG       = 100000;

    logic clk = 1'b0;
    logic rst_n, sw_store_req, sw_recall_req, sup_low, sup_dead, wr_stb, chip_sel;
    logic ph_erase, ph_program, ph_clear, ph_load, busy, bus_en, standby, dirty;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;
    bit finished = 1'b0;

    int    exp_code[$];
    int    exp_len[$];
    string exp_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nvx_seq #(
        .AUTO_DELAY_CYC (AUTO_DELAY_CYC),
        .ERASE_CYC      (ERASE_CYC),
        .PROG_CYC       (PROG_CYC),
        .CLEAR_CYC      (CLEAR_CYC),
        .SWLOAD_CYC     (SWLOAD_CYC),
        .RESTLOAD_CYC   (RESTLOAD_CYC)
    ) u_nvx_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_store_req  (sw_store_req),
        .sw_recall_req (sw_recall_req),
        .sup_low       (sup_low),
        .sup_dead      (sup_dead),
        .wr_stb        (wr_stb),
        .chip_sel      (chip_sel),
        .ph_erase      (ph_erase),
        .ph_program    (ph_program),
        .ph_clear      (ph_clear),
        .ph_load       (ph_load),
        .busy          (busy),
        .bus_en        (bus_en),
        .standby       (standby),
        .dirty         (dirty)
    );

    task automatic chk(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // phase codes: 1 erase, 2 program, 3 clear, 4 load; item = code*1000+length
    task automatic expect_ph(input int code, input int len, input string tag);
        exp_code.push_back(code);
        exp_len.push_back(len);
        exp_tag.push_back(tag);
    endtask

    task automatic finish_run(input int code, input int len);
        if (exp_code.size() == 0) begin
            chk("R8_R10 unexpected phase", code * 1000 + len, 0);
        end else begin
            int ec, el;
            string et;
            ec = exp_code.pop_front();
            el = exp_len.pop_front();
            et = exp_tag.pop_front();
            chk(et, code * 1000 + len, ec * 1000 + el);
        end
    endtask

    int cur_code = 0;
    int run_len  = 0;
    always @(negedge clk) begin
        int code;
        code = ph_erase ? 1 : ph_program ? 2 : ph_clear ? 3 : ph_load ? 4 : 0;
        if (code == cur_code) begin
            run_len++;
        end else begin
            if (cur_code != 0) finish_run(cur_code, run_len);
            cur_code = code;
            run_len  = 1;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_wr();
        @(negedge clk); wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic pulse_store();
        @(negedge clk); sw_store_req = 1'b1;
        @(negedge clk); sw_store_req = 1'b0;
    endtask

    task automatic pulse_recall();
        @(negedge clk); sw_recall_req = 1'b1;
        @(negedge clk); sw_recall_req = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, WATCHDOG);
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; sw_store_req = 1'b0; sw_recall_req = 1'b0;
        sup_low = 1'b0; sup_dead = 1'b0; wr_stb = 1'b0; chip_sel = 1'b1;

        // R1: power-up restore
        expect_ph(3, CLEAR_CYC, "R1 restore clear");
        expect_ph(4, RESTLOAD_CYC, "R1 restore load");
        cyc(3);
        chk("R1 bus off in reset", bus_en, 0);
        chk("R1 not busy in reset", busy, 0);
        rst_n = 1'b1;
        cyc(30);
        chk("R1 bus on after restore", bus_en, 1);
        chk("R1 clean after restore", dirty, 0);
        chk("R1 queue drained", exp_code.size(), 0);

        // R2/R4/R5/R6: dirty software store
        pulse_wr();
        chk("R5 write sets flag", dirty, 1);
        expect_ph(1, ERASE_CYC, "R2 erase");
        expect_ph(2, PROG_CYC, "R2 program");
        pulse_store();
        chk("R2 erase next edge", ph_erase, 1);
        chk("R4 bus off busy", bus_en, 0);
        chk("R4 busy high", busy, 1);
        chip_sel = 1'b0;
        #1;
        chk("R4 no standby while busy", standby, 0);
        cyc(30);
        chk("R4 standby when idle", standby, 1);
        chk("R6 clean after store", dirty, 0);
        chk("R2 queue drained", exp_code.size(), 0);
        chip_sel = 1'b1;

        // R3/R6: software recall
        pulse_wr();
        expect_ph(3, CLEAR_CYC, "R3 clear");
        expect_ph(4, SWLOAD_CYC, "R3 load");
        pulse_recall();
        chk("R3 clear next edge", ph_clear, 1);
        cyc(30);
        chk("R6 clean after recall", dirty, 0);
        chk("R3 queue drained", exp_code.size(), 0);

        // R2/R5: clean store still runs, write during it ignored
        expect_ph(1, ERASE_CYC, "R2 clean erase");
        expect_ph(2, PROG_CYC, "R2 clean program");
        pulse_store();
        pulse_wr();
        chk("R5 busy write ignored", dirty, 0);
        cyc(30);
        chk("R2 clean store drained", exp_code.size(), 0);

        // R8/R10/R5: clean brown-out, no store, requests rejected
        @(negedge clk); sup_low = 1'b1;
        cyc(10);
        chk("R8 no busy", busy, 0);
        chk("R8 bus off low supply", bus_en, 0);
        pulse_wr();
        pulse_store();
        pulse_recall();
        cyc(5);
        chk("R8 still idle phases", busy, 0);
        sup_low = 1'b0;
        cyc(30);
        chk("R5 low-supply write ignored", dirty, 0);
        chk("R10 bus back on", bus_en, 1);
        chk("R8 no phase ran", exp_code.size(), 0);

        // R7/R10: dirty brown-out with automatic store
        pulse_wr();
        expect_ph(1, ERASE_CYC, "R7 auto erase");
        expect_ph(2, PROG_CYC, "R7 auto program");
        sup_low = 1'b1;
        @(negedge clk);
        chk("R7 bus on in grace", bus_en, 1);
        begin
            int n = 0;
            while (!ph_erase && n < 50) begin
                n++;
                @(negedge clk);
            end
            chk("R7 grace length", n, AUTO_DELAY_CYC);
        end
        cyc(30);
        chk("R7 bus off after auto store", bus_en, 0);
        chk("R6 clean after auto store", dirty, 0);
        sup_low = 1'b0;
        cyc(30);
        chk("R10 bus on no recall", bus_en, 1);
        chk("R10 queue drained", exp_code.size(), 0);

        // R9: deep outage -> store then restore
        pulse_wr();
        expect_ph(1, ERASE_CYC, "R9 erase");
        expect_ph(2, PROG_CYC, "R9 program");
        expect_ph(3, CLEAR_CYC, "R9 restore clear");
        expect_ph(4, RESTLOAD_CYC, "R9 restore load");
        sup_low = 1'b1;
        cyc(30);
        sup_dead = 1'b1;
        cyc(3);
        sup_dead = 1'b0;
        cyc(3);
        sup_low = 1'b0;
        @(negedge clk);
        chk("R9 restore at crossing", ph_clear, 1);
        cyc(40);
        chk("R9 queue drained", exp_code.size(), 0);
        chk("R9 bus on", bus_en, 1);

        // R11: same-cycle priority
        pulse_wr();
        expect_ph(1, ERASE_CYC, "R11 erase");
        expect_ph(2, PROG_CYC, "R11 program");
        sup_low = 1'b1;
        sw_store_req = 1'b1;
        @(negedge clk);
        sw_store_req = 1'b0;
        chk("R11 no direct erase", ph_erase, 0);
        chk("R11 grace first", bus_en, 1);
        cyc(30);
        sup_low = 1'b0;
        cyc(30);
        chk("R11 queue drained", exp_code.size(), 0);

        summary();
    end
endmodule